// File: doc/BRIEF.md
# Privilege Mode and Machine Status Controller

This block keeps track of the privilege level a hart runs at and maintains the machine status fields that change on trap entry and trap return. Only two levels exist: machine and user. Trap delegation is fixed off, so any trap or interrupt always brings the hart into machine mode. The block takes a one-cycle trap strobe, a one-cycle trap-return (MRET) strobe and a write port for the machine status register. It returns the current mode, the status word as software reads it, and a global interrupt enable that already accounts for privilege.

A trap saves the interrupt enable into its "previous" slot, clears the enable, records the interrupted mode in the previous-privilege field and enters machine mode. An MRET reverses this. It restores the mode and the enable, sets the previous enable to one, and sets the previous-privilege field to user. When the target of the return is user mode, it also clears the modify-privilege bit. Software writes cannot put an unsupported code into the previous-privilege field, and the user XLEN field always reads as the 64-bit code.

Top module: `priv_status_ctrl`

## Requirements
- R1: After a synchronous reset, the mode is machine (2'b11), MIE, MPIE, MPRV and TW are 0, and MPP reads as machine (2'b11).
- R2: The status word places MIE at bit 3, MPIE at bit 7, MPP at bits 12:11, MPRV at bit 17, TW at bit 21 and UXL at bits 33:32. Every other bit reads as 0.
- R3: A trap strobe sets MPIE to the old MIE, clears MIE, loads MPP with the mode active before the trap, and puts the mode in machine. All of this is visible one cycle later.
- R4: An MRET strobe sets the mode to the old MPP, MIE to the old MPIE, MPIE to 1 and MPP to user (2'b00).
- R5: An MRET that returns to user mode clears MPRV. An MRET that returns to machine mode leaves MPRV unchanged.
- R6: A status write with neither strobe present loads MIE, MPIE, MPRV and TW from the write data at their R2 positions. It loads MPP when the written code is 2'b00 or 2'b11.
- R7: A status write with MPP code 2'b01 or 2'b10 leaves MPP at its previous value, while the other writable fields still update.
- R8: UXL always reads 2'b10, whatever value is written to bits 33:32.
- R9: The global interrupt enable output is 1 in user mode regardless of MIE, and equals MIE in machine mode.
- R10: When strobes or a write coincide, the trap takes precedence over MRET, and MRET takes precedence over a status write. The write is dropped in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_take | input | 1 | One-cycle strobe: a trap or interrupt is being taken |
| mret_take | input | 1 | One-cycle strobe: an MRET is retiring |
| csr_wr_en | input | 1 | Status register write enable |
| csr_wr_data | input | XLEN | Status register write data |
| cur_mode | output | 2 | Current privilege level (2'b11 machine, 2'b00 user) |
| status_rdata | output | XLEN | Status word as read by software |
| irq_global_en | output | 1 | Global machine interrupt enable after privilege masking |

## Verification
The bench first writes MPP codes 01 and 10 together with other field changes. A design that writes the field blindly would then read back a reserved mode, or it would reject the whole write. The bench then issues MRET to machine mode and to user mode with MPRV set, which catches a design that clears MPRV on every return or on none. It drives a trap together with MRET, and MRET together with a write: with the wrong priority the hart ends in user mode, or the write overwrites the restored fields. It also sits in user mode with MIE at 0 to check that the interrupt enable output is still forced on there.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic [1:0] {
        MODE_U = 2'b00,
        MODE_M = 2'b11
    } priv_mode_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TRAP,
        EV_MRET,
        EV_CSRW
    } status_event_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        priv_mode_e mpp;
        logic       mprv;
        logic       tw;
    } mstat_fields_t;

    localparam int BIT_MIE    = 3;
    localparam int BIT_MPIE   = 7;
    localparam int BIT_MPP_LO = 11;
    localparam int BIT_MPRV   = 17;
    localparam int BIT_TW     = 21;
    localparam int BIT_UXL_LO = 32;
    localparam logic [1:0] UXL_CODE = 2'b10;

    function automatic logic mpp_is_legal(input logic [1:0] code);
        return (code == 2'b00) || (code == 2'b11);
    endfunction

    function automatic status_event_e pick_event(input logic trap, input logic mret,
                                                 input logic wr);
        if (trap)      return EV_TRAP;
        else if (mret) return EV_MRET;
        else if (wr)   return EV_CSRW;
        else           return EV_NONE;
    endfunction

endpackage

// File: rtl/priv_mode_reg.sv
module priv_mode_reg
    import priv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  status_event_e ev,
    input  priv_mode_e    mpp_now,
    output priv_mode_e    mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_M;
        end else begin
            case (ev)
                EV_TRAP: mode <= MODE_M;
                EV_MRET: mode <= mpp_now;
                default: mode <= mode;
            endcase
        end
    end

    AST_TRAP_ENTERS_M: assert property (@(posedge clk) disable iff (rst)
        ev == EV_TRAP |=> mode == MODE_M); // R3
    AST_MRET_RESTORES_MODE: assert property (@(posedge clk) disable iff (rst)
        ev == EV_MRET |=> mode == $past(mpp_now)); // R4

endmodule

// File: rtl/priv_status_fields.sv
module priv_status_fields
    import priv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  status_event_e   ev,
    input  priv_mode_e      cur_mode,
    input  logic [XLEN-1:0] wr_data,
    output mstat_fields_t   fields
);

    logic [1:0] wr_mpp;
    assign wr_mpp = wr_data[BIT_MPP_LO+1:BIT_MPP_LO];

    always_ff @(posedge clk) begin
        if (rst) begin
            fields.mie  <= 1'b0;
            fields.mpie <= 1'b0;
            fields.mpp  <= MODE_M;
            fields.mprv <= 1'b0;
            fields.tw   <= 1'b0;
        end else begin
            case (ev)
                EV_TRAP: begin
                    fields.mpie <= fields.mie;
                    fields.mie  <= 1'b0;
                    fields.mpp  <= cur_mode;
                end
                EV_MRET: begin
                    fields.mie  <= fields.mpie;
                    fields.mpie <= 1'b1;
                    fields.mpp  <= MODE_U;
                    if (fields.mpp != MODE_M) fields.mprv <= 1'b0;
                end
                EV_CSRW: begin
                    fields.mie  <= wr_data[BIT_MIE];
                    fields.mpie <= wr_data[BIT_MPIE];
                    fields.mprv <= wr_data[BIT_MPRV];
                    fields.tw   <= wr_data[BIT_TW];
                    if (mpp_is_legal(wr_mpp)) fields.mpp <= priv_mode_e'(wr_mpp);
                end
                default: ;
            endcase
        end
    end

    AST_TRAP_SAVES_STATE: assert property (@(posedge clk) disable iff (rst)
        ev == EV_TRAP |=> fields.mpie == $past(fields.mie) && !fields.mie
                          && fields.mpp == $past(cur_mode)); // R3
    AST_MRET_CLEARS_MPRV: assert property (@(posedge clk) disable iff (rst)
        ev == EV_MRET && fields.mpp == MODE_U |=> !fields.mprv); // R5
    AST_MRET_SETS_MPIE: assert property (@(posedge clk) disable iff (rst)
        ev == EV_MRET |=> fields.mpie && fields.mpp == MODE_U); // R4
    AST_BAD_MPP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ev == EV_CSRW && !mpp_is_legal(wr_mpp) |=> $stable(fields.mpp)); // R7

endmodule

// File: rtl/priv_status_pack.sv
module priv_status_pack
    import priv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mstat_fields_t   fields,
    output logic [XLEN-1:0] word
);

    localparam bit HAS_UXL = (XLEN >= BIT_UXL_LO + 2);

    logic [XLEN-1:0] base;

    always_comb begin
        base = '0;
        base[BIT_MIE]                   = fields.mie;
        base[BIT_MPIE]                  = fields.mpie;
        base[BIT_MPP_LO+1:BIT_MPP_LO]   = fields.mpp;
        base[BIT_MPRV]                  = fields.mprv;
        base[BIT_TW]                    = fields.tw;
    end

    generate
        if (HAS_UXL) begin : g_uxl
            always_comb begin
                word = base;
                word[BIT_UXL_LO+1:BIT_UXL_LO] = UXL_CODE;
            end
        end else begin : g_no_uxl
            assign word = base;
        end
    endgenerate

endmodule

// File: rtl/priv_irq_gate.sv
module priv_irq_gate
    import priv_pkg::*;
(
    input  priv_mode_e mode,
    input  logic       mie,
    output logic       irq_en
);

    always_comb begin
        unique case (mode)
            MODE_U:  irq_en = 1'b1;
            default: irq_en = mie;
        endcase
    end

endmodule

// File: rtl/priv_status_ctrl.sv
module priv_status_ctrl
    import priv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_take,
    input  logic            mret_take,
    input  logic            csr_wr_en,
    input  logic [XLEN-1:0] csr_wr_data,
    output logic [1:0]      cur_mode,
    output logic [XLEN-1:0] status_rdata,
    output logic            irq_global_en
);

    status_event_e ev;
    priv_mode_e    mode;
    mstat_fields_t fields;

    assign ev       = pick_event(trap_take, mret_take, csr_wr_en);
    assign cur_mode = mode;

    priv_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .mpp_now (fields.mpp),
        .mode    (mode)
    );

    priv_status_fields #(.XLEN(XLEN)) u_fields (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cur_mode (mode),
        .wr_data  (csr_wr_data),
        .fields   (fields)
    );

    priv_status_pack #(.XLEN(XLEN)) u_pack (
        .fields (fields),
        .word   (status_rdata)
    );

    priv_irq_gate u_gate (
        .mode   (mode),
        .mie    (fields.mie),
        .irq_en (irq_global_en)
    );

    AST_USER_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 2'b00 |-> irq_global_en); // R9
    AST_TRAP_BEATS_MRET: assert property (@(posedge clk) disable iff (rst)
        trap_take && mret_take |=> cur_mode == 2'b11); // R10

    generate
        if (XLEN >= BIT_UXL_LO + 2) begin : g_uxl_chk
            AST_UXL_FIXED: assert property (@(posedge clk) disable iff (rst)
                status_rdata[BIT_UXL_LO+1:BIT_UXL_LO] == UXL_CODE); // R8
        end
    endgenerate

endmodule

// File: tb/priv_status_ctrl_test.sv
`timescale 1ns/1ps
module priv_status_ctrl_test;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            trap_take = 1'b0;
    logic            mret_take = 1'b0;
    logic            csr_wr_en = 1'b0;
    logic [XLEN-1:0] csr_wr_data = '0;
    logic [1:0]      cur_mode;
    logic [XLEN-1:0] status_rdata;
    logic            irq_global_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [1:0] m_mode, m_mpp;
    logic       m_mie, m_mpie, m_mprv, m_tw;

    always #4 clk = ~clk;

    priv_status_ctrl #(.XLEN(XLEN)) uut (
        .clk           (clk),
        .rst           (rst),
        .trap_take     (trap_take),
        .mret_take     (mret_take),
        .csr_wr_en     (csr_wr_en),
        .csr_wr_data   (csr_wr_data),
        .cur_mode      (cur_mode),
        .status_rdata  (status_rdata),
        .irq_global_en (irq_global_en)
    );

    function automatic logic [XLEN-1:0] model_word();
        logic [XLEN-1:0] w = '0;
        w[3]     = m_mie;
        w[7]     = m_mpie;
        w[12:11] = m_mpp;
        w[17]    = m_mprv;
        w[21]    = m_tw;
        w[33:32] = 2'b10;
        return w;
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, status_rdata, model_word(), "status");
        check(tag, {62'd0, cur_mode}, {62'd0, m_mode}, "mode");
        check(tag, {63'd0, irq_global_en},
              {63'd0, (m_mode == 2'b00) ? 1'b1 : m_mie}, "irq_en");
    endtask

    task automatic model_update(input logic t, input logic r, input logic w,
                                input logic [XLEN-1:0] d);
        logic [1:0] om = m_mode, op = m_mpp;
        logic oi = m_mie, opi = m_mpie;
        if (t) begin
            m_mpie = oi; m_mie = 1'b0; m_mpp = om; m_mode = 2'b11;
        end else if (r) begin
            m_mode = op; m_mie = opi; m_mpie = 1'b1; m_mpp = 2'b00;
            if (op != 2'b11) m_mprv = 1'b0;
        end else if (w) begin
            m_mie = d[3]; m_mpie = d[7]; m_mprv = d[17]; m_tw = d[21];
            if (d[12:11] == 2'b00 || d[12:11] == 2'b11) m_mpp = d[12:11];
        end
    endtask

    task automatic step(input string tag, input logic t, input logic r,
                        input logic w, input logic [XLEN-1:0] d);
        @(negedge clk);
        trap_take = t; mret_take = r; csr_wr_en = w; csr_wr_data = d;
        @(posedge clk);
        model_update(t, r, w, d);
        @(negedge clk);
        trap_take = 1'b0; mret_take = 1'b0; csr_wr_en = 1'b0; csr_wr_data = '0;
        compare_all(tag);
    endtask

    function automatic logic [XLEN-1:0] wdata(input logic mie, input logic mpie,
                                              input logic [1:0] mpp, input logic mprv,
                                              input logic tw);
        logic [XLEN-1:0] d = '0;
        d[3] = mie; d[7] = mpie; d[12:11] = mpp; d[17] = mprv; d[21] = tw;
        return d;
    endfunction

    task automatic test_reset();
        m_mode = 2'b11; m_mpp = 2'b11; m_mie = 0; m_mpie = 0; m_mprv = 0; m_tw = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare_all("R1");
        check("R2", status_rdata, 64'h2_0000_1800, "reset word layout");
    endtask

    task automatic test_csr_writes();
        step("R6", 0, 0, 1, wdata(1, 0, 2'b00, 1, 1));
        step("R9", 0, 0, 1, wdata(0, 1, 2'b11, 0, 0));
        step("R8", 0, 0, 1, '1);
        check("R2", status_rdata, 64'h2_0000_1800 | 64'h8 | 64'h80 | 64'h2_0000 | 64'h20_0000,
              "all-ones write");
    endtask

    task automatic test_bad_mpp();
        step("R7", 0, 0, 1, wdata(0, 0, 2'b01, 1, 0));
        step("R7", 0, 0, 1, wdata(1, 1, 2'b10, 0, 1));
    endtask

    task automatic test_trap_from_m();
        step("R3", 1, 0, 0, '0);
    endtask

    task automatic test_mret_to_m();
        step("R6", 0, 0, 1, wdata(0, 0, 2'b11, 1, 0));
        step("R5", 0, 1, 0, '0);
        check("R5", {63'd0, status_rdata[17]}, 64'd1, "MPRV kept on return to M");
    endtask

    task automatic test_user_round_trip();
        step("R6", 0, 0, 1, wdata(0, 0, 2'b00, 1, 1));
        step("R4", 0, 1, 0, '0);
        check("R5", {63'd0, status_rdata[17]}, 64'd0, "MPRV cleared on return to U");
        check("R9", {63'd0, irq_global_en}, 64'd1, "user mode irq forced on");
        step("R3", 1, 0, 0, '0);
    endtask

    task automatic test_priority();
        step("R6", 0, 0, 1, wdata(1, 0, 2'b00, 0, 0));
        step("R10", 1, 1, 0, '0);
        step("R6", 0, 0, 1, wdata(0, 1, 2'b00, 1, 0));
        step("R10", 0, 1, 1, wdata(0, 0, 2'b11, 1, 1));
        step("R10", 1, 0, 1, wdata(1, 1, 2'b00, 0, 1));
    endtask

    initial begin
        test_reset();
        test_csr_writes();
        test_bad_mpp();
        test_trap_from_m();
        test_mret_to_m();
        test_user_round_trip();
        test_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule